// File: doc/BRIEF.md
# Flash Chip-Erase Command Decoder

This block sits on the device side of a parallel NOR-style flash array model. It watches host write cycles and recognises the six-write unlock-and-erase command. When the last write of that command lands, it starts an internal erase engine. The engine first clears every word to zero and then runs a timed erase phase. At the end it sets every word to FFFFh and drops busy. While the engine runs, host reads return toggling status bits instead of array data, and host writes are dropped. An active-low asynchronous reset aborts the erase at once.

The host bus is a plain strobe bus with no back-pressure. A write is taken on every clock edge where `wr_en` is high. A read taken on an edge where `rd_en` is high returns its word on the following cycle, marked by `rd_valid`. The block never stalls the host, so the bus has no ready signal. The array model holds a small parameterised number of 16-bit words, and reset loads a fixed image into them. The erase time is `DEPTH + ERASE_CYCLES` clock cycles, so that runs stay short.

Top module: `flash_cmd_decoder`

## Requirements
- R1: With `byte_mode` low, the erase starts after six accepted writes in this order: AAh at 555h, 55h at 2AAh, 80h at 555h, AAh at 555h, 55h at 2AAh, 10h at 555h. The full address is compared and only data bits [7:0] are compared. `busy` is high from the clock edge that takes the sixth write.
- R2: With `byte_mode` high, the first unlock address is AAAh and the second is 555h. These replace 555h and 2AAh in every cycle of the sequence. The word-mode addresses do not start an erase in this mode.
- R3: A write that does not match the cycle expected next sends the decoder back to idle, so no erase follows. If that write matches the first cycle (AAh at the first unlock address), it begins a new sequence.
- R4: Writes taken while `busy` is high are ignored. They do not lengthen or restart the erase, and they do not advance the command sequence.
- R5: `busy` stays high for exactly DEPTH + ERASE_CYCLES clock cycles: a zeroing phase of one word per cycle, then a timed erase phase.
- R6: Once `busy` falls, every array word reads FFFFh.
- R7: A read taken with `rd_en` high sets `rd_valid` on the next cycle, with the word at `rd_addr` on `rd_data` when not busy. Reads do not disturb a partly entered command sequence.
- R8: While busy, reads return status. Bit 7 is 0. Bits 6 and 2 are equal: 0 on the first read after the erase starts, and inverted on each later read. All other bits are 0, so the data alternates between 0000h and 0044h.
- R9: Pulling `rst_n` low drops `busy` without waiting for a clock edge and clears any partly entered sequence. It also reloads the array so that word i holds ((i * 1357h) mod 10000h) XOR A5A5h.
- R10: During reset, `busy` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; aborts an erase |
| byte_mode | input | 1 | Selects byte-mode unlock addresses |
| wr_en | input | 1 | Host write strobe, one write per high cycle |
| wr_addr | input | ADDR_W | Host write address |
| wr_data | input | 16 | Host write data; bits [7:0] are the command code |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | $clog2(DEPTH) | Word index to read |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 16 | Array word, or status while busy |
| busy | output | 1 | Erase in progress |

## Verification
The bench aims at the points where a sequence decoder goes wrong.

- **Restart after a bad write.** A mismatching AAh write must restart the sequence; a decoder that only returns to idle would miss the erase that follows it.
- **Writes during the erase.** The bench sends a five-write prefix during the erase, then only the final 10h write after it ends. A decoder that kept counting writes while busy would start a spurious second erase.
- **Erase length.** The exact busy length catches off-by-one phase counters.
- **Status toggling.** Back-to-back status reads catch a status bit that does not toggle or starts from the wrong phase.
- **Abort on reset.** A reset taken mid-sequence and mid-erase must clear the partial sequence and reload the image. A decoder that kept a stale step count would fire on a bare tail of the sequence.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;

  typedef enum logic [1:0] {
    ENG_IDLE    = 2'd0,
    ENG_PREPROG = 2'd1,
    ENG_ERASE   = 2'd2
  } eng_state_e;

  // which of the two unlock addresses a cycle uses
  typedef enum logic {
    UNL_FIRST  = 1'b0,
    UNL_SECOND = 1'b1
  } unl_sel_e;

  typedef struct packed {
    unl_sel_e   sel;
    logic [7:0] code;
  } seq_step_t;

  localparam int unsigned SEQ_LEN = 6;
  localparam int unsigned STEP_W  = $clog2(SEQ_LEN);

  localparam logic [11:0] WORD_FIRST  = 12'h555;
  localparam logic [11:0] WORD_SECOND = 12'h2AA;
  localparam logic [11:0] BYTE_FIRST  = 12'hAAA;
  localparam logic [11:0] BYTE_SECOND = 12'h555;

  function automatic seq_step_t step_expect(input logic [STEP_W-1:0] idx);
    seq_step_t s;
    case (idx)
      3'd0:    s = '{sel: UNL_FIRST,  code: 8'hAA};
      3'd1:    s = '{sel: UNL_SECOND, code: 8'h55};
      3'd2:    s = '{sel: UNL_FIRST,  code: 8'h80};
      3'd3:    s = '{sel: UNL_FIRST,  code: 8'hAA};
      3'd4:    s = '{sel: UNL_SECOND, code: 8'h55};
      default: s = '{sel: UNL_FIRST,  code: 8'h10};
    endcase
    return s;
  endfunction

  // image loaded into the array model by reset
  function automatic logic [15:0] image_word(input int unsigned idx);
    logic [31:0] prod;
    prod = idx * 32'h1357;
    return prod[15:0] ^ 16'hA5A5;
  endfunction

endpackage

// File: rtl/fcs_seq_match.sv
`timescale 1ns/1ps
module fcs_seq_match
  import fcs_pkg::*;
#(
  parameter int unsigned ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_code,
  input  logic              busy,
  output logic              start
);

  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SEQ_LEN - 1);

  logic [STEP_W-1:0] step_q, step_d;
  seq_step_t         exp_cur, exp_head;
  logic              accept, hit_cur, hit_head;

  function automatic logic [ADDR_W-1:0] addr_of(input unl_sel_e sel, input logic bm);
    logic [11:0] a;
    if (bm) a = (sel == UNL_FIRST) ? BYTE_FIRST : BYTE_SECOND;
    else    a = (sel == UNL_FIRST) ? WORD_FIRST : WORD_SECOND;
    return ADDR_W'(a);
  endfunction

  always_comb begin
    exp_cur  = step_expect(step_q);
    exp_head = step_expect('0);
    accept   = wr_en && !busy;
    hit_cur  = (wr_addr == addr_of(exp_cur.sel, byte_mode)) && (wr_code == exp_cur.code);
    hit_head = (wr_addr == addr_of(exp_head.sel, byte_mode)) && (wr_code == exp_head.code);
    start    = accept && hit_cur && (step_q == LAST_STEP);
    step_d   = step_q;
    if (accept) begin
      if (hit_cur)       step_d = (step_q == LAST_STEP) ? '0 : step_q + 1'b1;
      else if (hit_head) step_d = STEP_W'(1);
      else               step_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) step_q <= '0;
    else        step_q <= step_d;
  end

  // R4: sequence position stays parked while the engine runs
  p_step_parked_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_q == '0));

endmodule

// File: rtl/fcs_erase_engine.sv
`timescale 1ns/1ps
module fcs_erase_engine
  import fcs_pkg::*;
#(
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned ERASE_CYCLES = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  output logic                     busy,
  output logic                     pp_we,
  output logic [$clog2(DEPTH)-1:0] pp_idx,
  output logic                     wipe
);

  localparam int unsigned IDX_W  = $clog2(DEPTH);
  localparam int unsigned CNT_MX = (DEPTH > ERASE_CYCLES) ? DEPTH : ERASE_CYCLES;
  localparam int unsigned CNT_W  = $clog2(CNT_MX + 1);
  localparam logic [CNT_W-1:0] PP_LAST = CNT_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] ER_LAST = CNT_W'(ERASE_CYCLES - 1);

  eng_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ENG_IDLE: if (start) begin
          state_q <= ENG_PREPROG;
          cnt_q   <= '0;
        end
        ENG_PREPROG: if (cnt_q == PP_LAST) begin
          state_q <= ENG_ERASE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        ENG_ERASE: if (cnt_q == ER_LAST) begin
          state_q <= ENG_IDLE;
          cnt_q   <= '0;
        end else cnt_q <= cnt_q + 1'b1;
        default: begin
          state_q <= ENG_IDLE;
          cnt_q   <= '0;
        end
      endcase
    end
  end

  always_comb begin
    busy   = (state_q != ENG_IDLE);
    pp_we  = (state_q == ENG_PREPROG);
    pp_idx = cnt_q[IDX_W-1:0];
    wipe   = (state_q == ENG_ERASE) && (cnt_q == ER_LAST);
  end

  // R1: busy only rises after a completed command
  p_rise_after_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R5: the erase phase is entered only from the zeroing phase
  p_erase_after_preprog_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ENG_ERASE && $past(state_q) != ENG_ERASE) |-> $past(state_q) == ENG_PREPROG);

endmodule

// File: rtl/fcs_array.sv
`timescale 1ns/1ps
module fcs_array
  import fcs_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pp_we,
  input  logic [$clog2(DEPTH)-1:0] pp_idx,
  input  logic                     wipe,
  input  logic                     start,
  input  logic                     busy,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic                     rd_valid,
  output logic [15:0]              rd_data
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0][15:0] mem;
  logic                   tog_q;
  logic                   sts_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    logic [15:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  word_q <= image_word(g);
      else if (wipe)                               word_q <= 16'hFFFF;
      else if (pp_we && pp_idx == IDX_W'(g))       word_q <= 16'h0000;
    end
    assign mem[g] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tog_q    <= 1'b0;
      sts_q    <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (start) tog_q <= 1'b0;
      if (rd_en) begin
        if (busy) begin
          rd_data <= {8'h00, 1'b0, tog_q, 3'b000, tog_q, 2'b00};
          tog_q   <= ~tog_q;
          sts_q   <= 1'b1;
        end else begin
          rd_data <= mem[rd_addr];
          sts_q   <= 1'b0;
        end
      end
    end
  end

  // R8: back-to-back status reads invert the toggle bit
  p_status_toggle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && sts_q && $past(rd_valid && sts_q)) |-> (rd_data[6] != $past(rd_data[6])));

  // R6: the final erase step leaves the words erased
  p_wipe_all_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wipe |=> (mem[0] == 16'hFFFF && mem[DEPTH-1] == 16'hFFFF));

endmodule

// File: rtl/flash_cmd_decoder.sv
`timescale 1ns/1ps
module flash_cmd_decoder
  import fcs_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned DEPTH        = 16,
  parameter int unsigned ERASE_CYCLES = 40
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     byte_mode,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [15:0]              wr_data,
  input  logic                     rd_en,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic                     rd_valid,
  output logic [15:0]              rd_data,
  output logic                     busy
);

  localparam int unsigned IDX_W = $clog2(DEPTH);

  logic             start;
  logic             pp_we;
  logic [IDX_W-1:0] pp_idx;
  logic             wipe;
  logic             unused_hi;

  assign unused_hi = ^wr_data[15:8];

  fcs_seq_match #(.ADDR_W(ADDR_W)) u_match (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_mode (byte_mode),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_code   (wr_data[7:0]),
    .busy      (busy),
    .start     (start)
  );

  fcs_erase_engine #(.DEPTH(DEPTH), .ERASE_CYCLES(ERASE_CYCLES)) u_engine (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (start),
    .busy   (busy),
    .pp_we  (pp_we),
    .pp_idx (pp_idx),
    .wipe   (wipe)
  );

  fcs_array #(.DEPTH(DEPTH)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .pp_we    (pp_we),
    .pp_idx   (pp_idx),
    .wipe     (wipe),
    .start    (start),
    .busy     (busy),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // R7: every read is answered on the next cycle
  p_read_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

endmodule

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

  localparam int ADDR_W       = 16;
  localparam int DEPTH        = 16;
  localparam int ERASE_CYCLES = 40;
  localparam int IDX_W        = $clog2(DEPTH);
  localparam int BUSY_LEN     = DEPTH + ERASE_CYCLES;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              byte_mode = 1'b0;
  logic              wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [15:0]       wr_data = '0;
  logic              rd_en = 1'b0;
  logic [IDX_W-1:0]  rd_addr = '0;
  logic              rd_valid;
  logic [15:0]       rd_data;
  logic              busy;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .ERASE_CYCLES(ERASE_CYCLES)) u_flash_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .busy(busy)
  );

  function automatic logic [15:0] img(input int i);
    logic [31:0] p;
    p = i * 4951;
    return p[15:0] ^ 16'hA5A5;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int idx, output logic [15:0] d, output logic v);
    @(negedge clk); rd_en = 1'b1; rd_addr = IDX_W'(idx);
    @(negedge clk); rd_en = 1'b0; d = rd_data; v = rd_valid;
  endtask

  task automatic full_seq(input logic [ADDR_W-1:0] a1, input logic [ADDR_W-1:0] a2);
    wr(a1, 16'h00AA); wr(a2, 16'h0055); wr(a1, 16'h0080);
    wr(a1, 16'h00AA); wr(a2, 16'h0055); wr(a1, 16'h0010);
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(busy == 1'b0, "R10 busy in reset", busy, 0);
    check(rd_valid == 1'b0, "R10 rd_valid in reset", rd_valid, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_image;
    logic [15:0] d; logic v;
    rd(0, d, v);       check(v && d == img(0), "R9 image word 0", d, img(0));
    rd(5, d, v);       check(v && d == img(5), "R7 image word 5", d, img(5));
    rd(DEPTH-1, d, v); check(v && d == img(DEPTH-1), "R9 image last word", d, img(DEPTH-1));
  endtask

  task automatic t_word_erase;
    int n; logic [15:0] d; logic v;
    wr(16'h0555, 16'h3CAA); wr(16'h02AA, 16'hC355); wr(16'h0555, 16'h7780);
    wr(16'h0555, 16'h01AA); wr(16'h02AA, 16'hFF55); wr(16'h0555, 16'h9910);
    check(busy == 1'b1, "R1 busy after sixth write", busy, 1);
    wait_idle(n);
    check(n == BUSY_LEN, "R5 busy length", n, BUSY_LEN);
    rd(0, d, v);       check(v && d == 16'hFFFF, "R6 word 0 erased", d, 16'hFFFF);
    rd(DEPTH-1, d, v); check(v && d == 16'hFFFF, "R6 last word erased", d, 16'hFFFF);
  endtask

  task automatic t_mismatch;
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0554, 16'h0080);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0010);
    check(busy == 1'b0, "R3 bad address aborts", busy, 0);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0056); wr(16'h0555, 16'h0080);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0010);
    check(busy == 1'b0, "R3 bad data aborts", busy, 0);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0080);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R3 five writes do not erase", busy, 0);
    wr(16'h0000, 16'h0000);
  endtask

  task automatic t_restart;
    int n;
    wr(16'h0555, 16'h00AA); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    wr(16'h0555, 16'h0080); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    wr(16'h0555, 16'h0010);
    check(busy == 1'b1, "R3 AAh mismatch restarts sequence", busy, 1);
    wait_idle(n);
  endtask

  task automatic t_read_between;
    int n; logic [15:0] d; logic v;
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    rd(3, d, v); check(v && d == 16'hFFFF, "R7 read mid-sequence", d, 16'hFFFF);
    wr(16'h0555, 16'h0080); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    wr(16'h0555, 16'h0010);
    check(busy == 1'b1, "R7 read keeps sequence", busy, 1);
    wait_idle(n);
  endtask

  task automatic t_byte;
    int n; logic [15:0] d; logic v;
    byte_mode = 1'b1;
    full_seq(16'h0555, 16'h02AA);
    check(busy == 1'b0, "R2 word addresses ignored in byte mode", busy, 0);
    full_seq(16'h0AAA, 16'h0555);
    check(busy == 1'b1, "R2 byte-mode erase starts", busy, 1);
    rd(1, d, v); check(v && d == 16'h0000, "R8 first status read", d, 16'h0000);
    rd(1, d, v); check(v && d == 16'h0044, "R8 second status read", d, 16'h0044);
    rd(1, d, v); check(v && d == 16'h0000, "R8 third status read", d, 16'h0000);
    wait_idle(n);
    check(n == BUSY_LEN - 6, "R5 byte-mode busy length", n, BUSY_LEN - 6);
    byte_mode = 1'b0;
  endtask

  task automatic t_ignore;
    int n;
    full_seq(16'h0555, 16'h02AA);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0555, 16'h0080);
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055); wr(16'h0000, 16'h0000);
    wait_idle(n);
    check(n == BUSY_LEN - 12, "R4 writes do not extend erase", n, BUSY_LEN - 12);
    wr(16'h0555, 16'h0010);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R4 busy writes did not advance sequence", busy, 0);
  endtask

  task automatic t_abort;
    int n; logic [15:0] d; logic v;
    full_seq(16'h0555, 16'h02AA);
    repeat (10) @(negedge clk);
    rst_n = 1'b0; #1;
    check(busy == 1'b0, "R9 reset drops busy at once", busy, 0);
    @(negedge clk); rst_n = 1'b1;
    rd(2, d, v); check(v && d == img(2), "R9 image reloaded", d, img(2));
    wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    wr(16'h0555, 16'h0080); wr(16'h0555, 16'h00AA); wr(16'h02AA, 16'h0055);
    wr(16'h0555, 16'h0010);
    check(busy == 1'b0, "R9 partial sequence cleared", busy, 0);
    full_seq(16'h0555, 16'h02AA);
    wait_idle(n);
    rd(7, d, v); check(v && d == 16'hFFFF, "R6 erase after abort", d, 16'hFFFF);
  endtask

  initial begin
    t_reset();
    t_image();
    t_word_erase();
    t_mismatch();
    t_restart();
    t_read_between();
    t_byte();
    t_ignore();
    t_abort();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule